// File: doc/BRIEF.md
# Lane Word-to-Sample Unpacker for a 64b/66b Receive Link

This block sits behind the receive lanes of a 64b/66b serial converter link. Each lane hands over one 64-bit word per clock while the input valid is high. The block collects three words from each lane into a 192-bit group and starts each group on the word flagged by the extended-multiblock pulse. It then cuts every group into sixteen 12-bit real samples. The samples are packed tightly, with no padding between them.

All eight lanes are handled in parallel, each as its own channel. The result is a 1536-bit bus ordered by lane and then by sample index, qualified by a one-cycle strobe. If the alignment pulse arrives in the middle of a group, the partial group is dropped, collection restarts on that word, and a sticky error flag is raised.

Top module: `jsu_unpacker`

## Requirements
- R1: The first captured word of a group fills group bits 191:128, the second fills 127:64 and the third fills 63:0. The first word of a group is the one taken with `emb_pulse` high or the one that follows a completed group.
- R2: Within a 192-bit group, sample k (k = 0..15) is group bits [191-12k -: 12], so sample 0 is the top 12 bits of the first word and sample 15 is the low 12 bits of the third word.
- R3: Lane l takes its input word from `lane_data[64l +: 64]`, and its sample s appears on `samples[(16l+s)*12 +: 12]`. Each lane is an independent real channel, and lanes are never combined.
- R4: `out_valid` is high for exactly one cycle: the cycle after the third word of a group is captured. At that cycle `samples` shows that group.
- R5: After reset no word is captured and `out_valid` stays low until an input word arrives with `emb_pulse` high.
- R6: A word taken with `emb_pulse` high when one or two words of the current group are already held discards that partial group and becomes word 0 of a new group. No strobe is produced for the dropped group, and `realign_err` goes high and stays high until reset.
- R7: While `in_valid` is low, neither the word count nor the stored words change, and `lane_data` is ignored. A group whose words are separated by idle cycles is output the same as a group sent back-to-back.
- R8: A synchronous active-low reset (`rst_n` low at a clock edge) clears the word count, `out_valid`, `realign_err` and the alignment state.
- R9: An `emb_pulse` on the first word of a new group, when no partial group is held, sets no error. Groups with no pulse continue in sequence after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Lane words present this cycle |
| emb_pulse | input | 1 | Current word begins an extended multiblock (qualified by in_valid) |
| lane_data | input | 512 | One 64-bit word per lane, lane l at bits 64l+63:64l |
| out_valid | output | 1 | One-cycle strobe: samples hold a complete group |
| samples | output | 1536 | Lane-major, sample-minor 12-bit real samples |
| realign_err | output | 1 | Sticky flag: alignment pulse seen mid-group |

## Verification
The sample values are chosen so that 32 consecutive groups across all lanes and sample slots cover every 12-bit code exactly once. Any bit slip, reversed sample order or lane swap therefore yields a wrong code at some position. The same groups are also sent with idle cycles between their words, which separates correct hold behaviour from capture of garbage data. A pulse one word and two words into a group tests the discard-and-restart path and the sticky flag. Groups sent before the first pulse and after a reset check that capture stays off until alignment. A pulse on a group boundary confirms that a correctly phased pulse raises no error.

// File: rtl/jsu_pkg.sv
// Package: shared types for the lane unpacker.
// Holds the alignment state encoding used by the phase controller.
package jsu_pkg;
    typedef enum logic {
        ALIGN_SEARCH = 1'b0,
        ALIGN_RUN    = 1'b1
    } align_state_t;
endpackage

// File: rtl/jsu_phase_ctrl.sv
// Module: jsu_phase_ctrl
// Tracks the word position within a group, shared by all lanes.
// Produces the capture enable, the group-complete strobe and the
// sticky realignment error flag.
// Assumes: emb_pulse is only meaningful while in_valid is high.
module jsu_phase_ctrl
    import jsu_pkg::*;
#(
    parameter int WORDS_PER_GROUP = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic emb_pulse,
    output logic cap_en,
    output logic out_valid,
    output logic realign_err
);
    localparam int CW = (WORDS_PER_GROUP > 1) ? $clog2(WORDS_PER_GROUP) : 1;
    localparam logic [CW-1:0] LAST = CW'(WORDS_PER_GROUP - 1);

    align_state_t    state;
    logic [CW-1:0]   cnt;
    logic [CW-1:0]   idx;
    logic            done;
    logic            misphase;

    // Position of the current word: a pulse forces position zero.
    always_comb begin
        idx      = emb_pulse ? '0 : cnt;
        done     = (idx == LAST);
        misphase = emb_pulse && (state == ALIGN_RUN) && (cnt != '0);
        cap_en   = in_valid && (emb_pulse || state == ALIGN_RUN);
    end

    // Advance word count, emit strobe on group completion, latch misphase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ALIGN_SEARCH;
            cnt         <= '0;
            out_valid   <= 1'b0;
            realign_err <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            if (cap_en) begin
                state     <= ALIGN_RUN;
                cnt       <= done ? '0 : idx + 1'b1;
                out_valid <= done;
                if (misphase)
                    realign_err <= 1'b1;
            end
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST); // R1
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(cnt) && !out_valid); // R7
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        realign_err |=> realign_err); // R6
    AST_MISPHASE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && misphase |=> realign_err); // R6
    AST_SEARCH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ALIGN_SEARCH) && !(in_valid && emb_pulse) |=> !out_valid); // R5

    generate
        if (WORDS_PER_GROUP > 1) begin : g_multi
            AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
                out_valid |=> !out_valid); // R4
            AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid && emb_pulse |=> (cnt == CW'(1)) && !out_valid); // R6
        end
    endgenerate
endmodule

// File: rtl/jsu_lane_gather.sv
// Module: jsu_lane_gather
// Collects consecutive words of one lane into a group register,
// oldest word at the top. After a full group of captures the first
// word sits in the most significant position.
// Assumes: cap_en comes from the shared phase controller.
module jsu_lane_gather #(
    parameter int WORD_W          = 64,
    parameter int WORDS_PER_GROUP = 3
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                cap_en,
    input  logic [WORD_W-1:0]                   word_in,
    output logic [WORD_W*WORDS_PER_GROUP-1:0]   group_out
);
    localparam int GROUP_W = WORD_W * WORDS_PER_GROUP;

    logic [GROUP_W-1:0] shreg;

    // Shift the new word in at the bottom on each capture.
    always_ff @(posedge clk) begin
        if (!rst_n)
            shreg <= '0;
        else if (cap_en)
            shreg <= {shreg[GROUP_W-WORD_W-1:0], word_in};
    end

    assign group_out = shreg;

    AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en |=> $stable(shreg)); // R7
endmodule

// File: rtl/jsu_sample_split.sv
// Module: jsu_sample_split
// Cuts a group into tightly packed samples, sample 0 at the group's
// top, and places sample s at the low end of the output plus s slots.
// Assumes: GROUP_W is a whole multiple of SAMPLE_W.
module jsu_sample_split #(
    parameter int GROUP_W  = 192,
    parameter int SAMPLE_W = 12
) (
    input  logic [GROUP_W-1:0] group_in,
    output logic [GROUP_W-1:0] samples_out
);
    localparam int NSAMP = GROUP_W / SAMPLE_W;

    generate
        for (genvar s = 0; s < NSAMP; s++) begin : g_samp
            // Reverse slot order: top of group becomes slot zero.
            assign samples_out[s*SAMPLE_W +: SAMPLE_W] =
                group_in[GROUP_W-1-s*SAMPLE_W -: SAMPLE_W];
        end
    endgenerate
endmodule

// File: rtl/jsu_unpacker.sv
// Module: jsu_unpacker
// Top: one phase controller shared by all lanes, one gatherer and one
// splitter per lane. The output bus is lane-major, sample-minor.
// Assumes: all lanes are word-aligned to each other on input.
module jsu_unpacker #(
    parameter int LANES           = 8,
    parameter int WORD_W          = 64,
    parameter int WORDS_PER_GROUP = 3,
    parameter int SAMPLE_W        = 12
) (
    input  logic                                          clk,
    input  logic                                          rst_n,
    input  logic                                          in_valid,
    input  logic                                          emb_pulse,
    input  logic [LANES*WORD_W-1:0]                       lane_data,
    output logic                                          out_valid,
    output logic [LANES*WORD_W*WORDS_PER_GROUP-1:0]       samples,
    output logic                                          realign_err
);
    localparam int GROUP_W = WORD_W * WORDS_PER_GROUP;

    logic cap_en;

    jsu_phase_ctrl #(.WORDS_PER_GROUP(WORDS_PER_GROUP)) u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .emb_pulse  (emb_pulse),
        .cap_en     (cap_en),
        .out_valid  (out_valid),
        .realign_err(realign_err)
    );

    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            logic [GROUP_W-1:0] grp;

            jsu_lane_gather #(
                .WORD_W         (WORD_W),
                .WORDS_PER_GROUP(WORDS_PER_GROUP)
            ) u_gather (
                .clk      (clk),
                .rst_n    (rst_n),
                .cap_en   (cap_en),
                .word_in  (lane_data[l*WORD_W +: WORD_W]),
                .group_out(grp)
            );

            jsu_sample_split #(
                .GROUP_W (GROUP_W),
                .SAMPLE_W(SAMPLE_W)
            ) u_split (
                .group_in   (grp),
                .samples_out(samples[l*GROUP_W +: GROUP_W])
            );
        end
    endgenerate

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> !out_valid && !realign_err); // R8
endmodule

// File: tb/jsu_unpacker_test.sv
// Bench: sweeps sample codes exhaustively through all lanes and slots,
// with back-to-back words, gapped words, misphased pulses and reset.
module jsu_unpacker_test;
    localparam int CLK_PERIOD = 10;
    localparam int LANES = 8;
    localparam int WW    = 64;
    localparam int GW    = 192;
    localparam int NS    = 16;

    logic                clk = 1'b0;
    logic                rst_n;
    logic                in_valid;
    logic                emb_pulse;
    logic [LANES*WW-1:0] lane_data;
    logic                out_valid;
    logic [LANES*GW-1:0] samples;
    logic                realign_err;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    jsu_unpacker uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .emb_pulse(emb_pulse),
        .lane_data(lane_data), .out_valid(out_valid), .samples(samples),
        .realign_err(realign_err)
    );

    function automatic logic [11:0] sval(int l, int g, int s);
        return 12'(((g*128 + l*16 + s) * 37 + 5) % 4096);
    endfunction

    function automatic logic [GW-1:0] grp_bits(int l, int g);
        logic [GW-1:0] r;
        for (int s = 0; s < NS; s++) r[GW-1-12*s -: 12] = sval(l, g, s);
        return r;
    endfunction

    function automatic logic [LANES*WW-1:0] bus_word(int g, int w);
        logic [LANES*WW-1:0] b;
        for (int l = 0; l < LANES; l++) begin
            logic [GW-1:0] t;
            t = grp_bits(l, g);
            b[l*WW +: WW] = t[GW-1-WW*w -: WW];
        end
        return b;
    endfunction

    task automatic chk(bit ok, string req, logic [GW-1:0] act, logic [GW-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Compare all lanes against group g (R2, R3).
    task automatic chk_samples(int g, string req);
        for (int l = 0; l < LANES; l++) begin
            logic [GW-1:0] e;
            for (int s = 0; s < NS; s++) e[s*12 +: 12] = sval(l, g, s);
            chk(samples[l*GW +: GW] === e, req, samples[l*GW +: GW], e);
        end
    endtask

    // Send one group; gap inserts idle cycles with garbage data between words.
    task automatic send_group(int g, bit pulse, int gap, bit expect_out, string req);
        for (int w = 0; w < 3; w++) begin
            if (w > 0) begin
                for (int k = 0; k < gap; k++) begin
                    @(negedge clk);
                    chk(out_valid === 1'b0, "R7 idle no strobe", GW'(out_valid), '0);
                    in_valid  = 1'b0;
                    emb_pulse = 1'b1;
                    lane_data = {LANES{64'hA5A5_F00D_DEAD_BEEF}};
                end
            end
            @(negedge clk);
            if (w > 0)
                chk(out_valid === 1'b0, "R4 no mid-group strobe", GW'(out_valid), '0);
            in_valid  = 1'b1;
            emb_pulse = (w == 0) && pulse;
            lane_data = bus_word(g, w);
        end
        @(negedge clk);
        in_valid  = 1'b0;
        emb_pulse = 1'b0;
        lane_data = '0;
        chk(out_valid === expect_out, {req, " strobe"}, GW'(out_valid), GW'(expect_out));
        if (expect_out) chk_samples(g, {req, " R1 R2 R3 samples"});
        @(negedge clk);
        chk(out_valid === 1'b0, "R4 strobe one cycle", GW'(out_valid), '0);
    endtask

    task automatic partial(int g, int n, bit pulse);
        for (int w = 0; w < n; w++) begin
            @(negedge clk);
            in_valid  = 1'b1;
            emb_pulse = (w == 0) && pulse;
            lane_data = bus_word(g, w);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0; emb_pulse = 1'b0; lane_data = '0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; emb_pulse = 1'b0; lane_data = '0;
        do_reset();
        chk(out_valid === 1'b0, "R8 reset valid", GW'(out_valid), '0);
        chk(realign_err === 1'b0, "R8 reset err", GW'(realign_err), '0);

        // R5: nothing before the first pulse, even with valid words
        send_group(40, 1'b0, 0, 1'b0, "R5 before lock");

        // Main sweep: 32 groups cover every 12-bit code once (R1 R2 R3 R4 R9)
        for (int g = 0; g < 32; g++)
            send_group(g, (g % 8) == 0, 0, 1'b1, "R9 sweep");
        chk(realign_err === 1'b0, "R9 aligned pulses no error", GW'(realign_err), '0);

        // R7: gapped words give the same result
        for (int g = 0; g < 4; g++)
            send_group(g + 10, 1'b0, g + 1, 1'b1, "R7 gapped");
        chk(realign_err === 1'b0, "R7 no error", GW'(realign_err), '0);

        // R6: pulse after one word discards, restarts
        partial(50, 1, 1'b0);
        send_group(51, 1'b1, 0, 1'b1, "R6 restart after 1");
        chk(realign_err === 1'b1, "R6 err after 1", GW'(realign_err), 1);

        // R6: pulse after two words, plus stickiness over a good group
        partial(52, 2, 1'b0);
        send_group(53, 1'b1, 0, 1'b1, "R6 restart after 2");
        send_group(54, 1'b0, 0, 1'b1, "R6 follow-on");
        chk(realign_err === 1'b1, "R6 err sticky", GW'(realign_err), 1);

        // R8: reset clears error and alignment
        do_reset();
        chk(realign_err === 1'b0, "R8 err cleared", GW'(realign_err), '0);
        chk(out_valid === 1'b0, "R8 valid cleared", GW'(out_valid), '0);
        send_group(55, 1'b0, 0, 1'b0, "R8 R5 unaligned after reset");
        send_group(56, 1'b1, 0, 1'b1, "R8 realign after reset");

        // R8: reset mid-group drops the partial words
        partial(57, 2, 1'b1);
        do_reset();
        send_group(58, 1'b1, 0, 1'b1, "R8 mid-group reset");
        chk(realign_err === 1'b0, "R8 no error after mid reset", GW'(realign_err), '0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule